// File: doc/BRIEF.md
# Single-Precision Integer Remainder by 32

This block takes a single-precision floating-point word that carries an integer value and returns the remainder of that integer's magnitude after division by 32. The result is itself a single-precision word. The input sign passes straight through to the output, and the remainder is re-encoded in the three usual fields. It serves as the index step of a table-driven argument reduction: the five-bit remainder selects a table entry, and the float form feeds later arithmetic.

Internally, a small control unit turns the biased exponent into a set of strobes. These give the shift direction, the shift distance, and a forced-zero flag for values below one. The datapath restores the hidden bit and aligns the 24-bit magnitude so that its binary point sits at bit 0. It keeps five bits, finds their leading one, and normalizes. The arithmetic is purely combinational. An optional output register, present by default, adds one cycle of latency. NaN, infinity and inputs with a fractional part are not handled.

Top module: `fmod32_unit`

## Requirements
- R1: The output sign bit (bit 31) always equals the input sign bit.
- R2: An input integer from 0 through 31 gives back the same integer value, encoded as a float.
- R3: An input integer from 32 up to 2^24 - 1 (biased exponent 132 to 150) gives its magnitude modulo 32.
- R4: An input with biased exponent above 150 (left alignment of the magnitude) gives its magnitude modulo 32. For biased exponent 155 or more, this is always zero.
- R5: An input with biased exponent below 127 (magnitude below one, including zero) gives a zero remainder.
- R6: A zero remainder is encoded as exponent field 0 and fraction field 0, with the sign still copied.
- R7: A nonzero remainder whose highest set bit is at position k (0 to 4) gets biased exponent 127+k. Its remaining lower bits are placed left-justified in the 23-bit fraction field (bits 22:0).
- R8: With the default setting of one pipeline stage, the output shows the result for an input one clock edge after that input is applied. While the active-low reset is asserted, the output is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Asynchronous active-low reset |
| inFloat | input | 32 | Single-precision input holding an integer |
| outFloat | output | 32 | Single-precision remainder modulo 32 |

## Verification
The small integers 0 to 63 exercise every leading-one position and the right-alignment path, where the value either returns unchanged or wraps once. Multiples of 32 must all collapse to the zero encoding, which separates a correct mask from an off-by-one shift. Large integers between 2^24 and 2^30 take the left-alignment path. Their ulp grows past 32 there, so they show whether bits shifted in from the bottom are correctly zero. Values below one and negative inputs cover the forced-zero strobe and the sign path on its own.

// File: rtl/fmod32_pkg.sv
package fmod32_pkg;
  localparam int EXP_W  = 8;
  localparam int FRAC_W = 23;
  localparam int MAG_W  = FRAC_W + 1;
  localparam int REM_W  = 5;
  localparam int BIAS   = 127;
  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  typedef struct packed {
    logic             remZero;   // magnitude below one
    logic             goLeft;    // align by left shift
    logic [EXP_W-1:0] shiftAmt;  // alignment distance
  } ctlStrobes_t;
endpackage

// File: rtl/fmod32_ctl.sv
module fmod32_ctl
  import fmod32_pkg::*;
(
  input  logic [EXP_W-1:0] biasedExp,
  output ctlStrobes_t      strobes
);
  logic [EXP_W-1:0] unbiased;

  always_comb begin
    unbiased         = biasedExp - EXP_W'(BIAS);
    strobes.remZero  = unbiased[EXP_W-1];
    strobes.goLeft   = !unbiased[EXP_W-1] && (unbiased > EXP_W'(FRAC_W));
    strobes.shiftAmt = strobes.goLeft ? unbiased - EXP_W'(FRAC_W)
                                      : EXP_W'(FRAC_W) - unbiased;
  end
endmodule

// File: rtl/fmod32_dp.sv
module fmod32_dp
  import fmod32_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic [FRAC_W-1:0] fracIn,
  output logic [EXP_W-1:0]  resExp,
  output logic [FRAC_W-1:0] resFrac
);
  logic [MAG_W-1:0] mag;
  logic [REM_W-1:0] aligned;
  logic [REM_W-1:0] rem;
  logic [2:0]       leadPos;

  assign mag     = {1'b1, fracIn};
  assign aligned = strobes.goLeft ? REM_W'(mag << strobes.shiftAmt)
                                  : REM_W'(mag >> strobes.shiftAmt);
  assign rem     = strobes.remZero ? '0 : aligned;

  always_comb begin
    leadPos = '0;
    for (int i = 0; i < REM_W; i++) begin
      if (rem[i]) leadPos = 3'(i);
    end
  end

  always_comb begin
    if (rem == '0) begin
      resExp  = '0;
      resFrac = '0;
    end else begin
      resExp  = EXP_W'(BIAS) + EXP_W'(leadPos);
      resFrac = FRAC_W'(MAG_W'(rem) << (FRAC_W - int'(leadPos)));
    end
  end

  AST_NEG_EXP_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    strobes.remZero |-> (resExp == '0 && resFrac == '0)); // R5

  AST_ZERO_ENCODE: assert property (@(posedge clk) disable iff (!rstN)
    (rem == '0) |-> (resExp == '0 && resFrac == '0)); // R6

  AST_EXP_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (rem != '0) |-> (resExp >= EXP_W'(BIAS) && resExp <= EXP_W'(BIAS + REM_W - 1))); // R7

  AST_LEAD_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (rem != '0) |-> ((rem >> (resExp - EXP_W'(BIAS))) == REM_W'(1))); // R7
endmodule

// File: rtl/fmod32_unit.sv
module fmod32_unit
  import fmod32_pkg::*;
#(
  parameter int PIPE_STAGES = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [31:0]       inFloat,
  output logic [31:0]       outFloat
);
  ctlStrobes_t       strobes;
  logic [EXP_W-1:0]  resExp;
  logic [FRAC_W-1:0] resFrac;
  logic [WORD_W-1:0] resWord;

  fmod32_ctl uCtl (
    .biasedExp (inFloat[WORD_W-2 -: EXP_W]),
    .strobes   (strobes)
  );

  fmod32_dp uDp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .fracIn  (inFloat[FRAC_W-1:0]),
    .resExp  (resExp),
    .resFrac (resFrac)
  );

  assign resWord = {inFloat[WORD_W-1], resExp, resFrac};

  generate
    if (PIPE_STAGES == 0) begin : gComb
      assign outFloat = resWord;
      AST_SIGN_COMB: assert property (@(posedge clk) disable iff (!rstN)
        outFloat[WORD_W-1] == inFloat[WORD_W-1]); // R1
    end else begin : gReg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) outFloat <= '0;
        else       outFloat <= resWord;
      end
      AST_SIGN_PIPE: assert property (@(posedge clk) disable iff (!rstN)
        1'b1 |=> outFloat[WORD_W-1] == $past(inFloat[WORD_W-1])); // R1
      AST_RESET_CLEAR: assert property (@(posedge clk)
        !rstN |-> outFloat == '0); // R8
    end
  endgenerate
endmodule

// File: tb/tb_fmod32_unit.sv
`timescale 1ns/1ps
module tb_fmod32_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] inF = '0;
  logic [31:0] outF;
  int          nChecks = 0;
  int          nFails = 0;
  bit          doneFlag = 1'b0;

  always #2.5 clk = ~clk;

  fmod32_unit dut (.clk(clk), .rstN(rstN), .inFloat(inF), .outFloat(outF));

  function automatic logic [31:0] mkFloat(input logic neg, input logic [31:0] mag);
    int p;
    logic [31:0] f;
    if (mag == 0) return {neg, 31'b0};
    p = 0;
    for (int i = 0; i < 32; i++) if (mag[i]) p = i;
    if (p <= 23) f = mag << (23 - p);
    else         f = mag >> (p - 23);
    return {neg, 8'(127 + p), f[22:0]};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [31:0] x, input logic [31:0] exp);
    @(negedge clk) inF = x;
    @(negedge clk) check(tag, outF, exp);
  endtask

  task automatic tReset;
    @(negedge clk) inF = mkFloat(1'b1, 32'd21);
    @(negedge clk) check("R8 reset output zero", outF, 32'h0);
    rstN = 1'b1;
  endtask

  task automatic tSmall;
    for (int n = 0; n < 32; n++)
      apply("R2 R7 small integer", mkFloat(1'b0, 32'(n)), mkFloat(1'b0, 32'(n)));
  endtask

  task automatic tMid;
    for (int n = 32; n < 64; n++)
      apply("R3 R7 wrap once", mkFloat(1'b0, 32'(n)), mkFloat(1'b0, 32'(n % 32)));
  endtask

  task automatic tMultiples;
    for (int k = 1; k < 40; k++)
      apply("R3 R6 multiple of 32", mkFloat(1'b0, 32'(k * 32)), 32'h0);
    apply("R3 R6 multiple near 2^24", mkFloat(1'b0, 32'h00FF_FFE0), 32'h0);
    apply("R3 R7 top of right path", mkFloat(1'b0, 32'h00FF_FFFF), mkFloat(1'b0, 32'd31));
    apply("R3 mid value", mkFloat(1'b0, 32'd123457), mkFloat(1'b0, 32'd1));
  endtask

  task automatic tLarge;
    apply("R4 exp 151", mkFloat(1'b0, 32'h0100_000E), mkFloat(1'b0, 32'd14));
    apply("R4 exp 152", mkFloat(1'b0, 32'h0200_001C), mkFloat(1'b0, 32'd28));
    apply("R4 exp 153", mkFloat(1'b0, 32'h0400_0018), mkFloat(1'b0, 32'd24));
    apply("R4 exp 154", mkFloat(1'b0, 32'h0800_0010), mkFloat(1'b0, 32'd16));
    apply("R4 2^30", mkFloat(1'b0, 32'h4000_0000), 32'h0);
    apply("R4 above 2^30", mkFloat(1'b0, 32'h4000_0080), 32'h0);
    apply("R4 below 2^30", mkFloat(1'b0, 32'h3FFF_FFC0), 32'h0);
    apply("R4 exp 155 dense", {1'b0, 8'd155, 23'h7FFFFF}, 32'h0);
  endtask

  task automatic tNegExp;
    apply("R5 R6 plus zero", 32'h0000_0000, 32'h0);
    apply("R5 R6 minus zero", 32'h8000_0000, 32'h8000_0000);
    apply("R5 half", {1'b0, 8'd126, 23'h0}, 32'h0);
    apply("R5 tiny", {1'b0, 8'd1, 23'h12345}, 32'h0);
    apply("R5 R1 negative below one", {1'b1, 8'd126, 23'h400000}, 32'h8000_0000);
  endtask

  task automatic tSign;
    apply("R1 negative 37", mkFloat(1'b1, 32'd37), mkFloat(1'b1, 32'd5));
    apply("R1 negative 31", mkFloat(1'b1, 32'd31), mkFloat(1'b1, 32'd31));
    apply("R1 R6 negative 64", mkFloat(1'b1, 32'd64), 32'h8000_0000);
    apply("R1 R4 negative large", mkFloat(1'b1, 32'h0100_0006), mkFloat(1'b1, 32'd6));
  endtask

  task automatic tLatency;
    @(negedge clk) inF = mkFloat(1'b0, 32'd3);
    @(negedge clk) inF = mkFloat(1'b0, 32'd17);
    #1 check("R8 previous result held before edge", outF, mkFloat(1'b0, 32'd3));
    @(negedge clk) check("R8 one edge latency", outF, mkFloat(1'b0, 32'd17));
  endtask

  initial begin
    tReset();
    tSmall();
    tMid();
    tMultiples();
    tLarge();
    tNegExp();
    tSign();
    tLatency();
    doneFlag = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    if (!doneFlag) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule